// File: doc/BRIEF.md
# Multicycle Shared-ALU Processor Core

This block is a compact 32-bit processor core. It executes each instruction as a short series of equal-length clock steps rather than as one long step. A single ALU serves every arithmetic need of an instruction: it increments the program counter, forms the branch destination, adds a base register to an offset and carries out register-to-register operations. A single word-addressed memory serves both instruction fetch and data access. Holding registers keep intermediate values from one step to the next: the instruction latch, the loaded-data latch, the two operand latches and the ALU result latch. Multiplexers steer the shared ALU and the shared memory in each step, and a small state machine drives every select and enable.

The memory sits inside the core. It can be written through a load port, which places a program and its data before the core runs. It writes on the clock edge and reads combinationally. The memory bus is visible at the ports, so stores and fetch addresses can be watched. The core raises a halt flag and stays idle once it decodes an instruction whose opcode field is zero.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high on a clock edge, the program counter becomes 0 and the controller returns to the fetch step. `halt` is low during reset.
- R2: Instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0] (sign-extended), jump target [25:0]. The opcodes are: 0x00 halt, 0x01 register arithmetic, 0x23 load word, 0x2B store word, 0x04 branch-if-equal and 0x02 jump.
- R3: Register arithmetic writes rs OP rt into rd and takes 4 cycles. The function codes are: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A signed set-less-than (result 1 or 0).
- R4: A load word writes the memory word at rs + sext(imm) into rt and takes 5 cycles.
- R5: A store word writes rt to byte address rs + sext(imm) and takes 4 cycles. The write shows at the ports as `mem_we` high, with `mem_addr` and `mem_wdata` valid in that cycle.
- R6: A branch-if-equal takes 3 cycles. When rs equals rt it moves the PC to (address of the branch + 4) + (sext(imm) << 2). Otherwise execution continues with the next instruction.
- R7: A jump takes 3 cycles and sets the PC to {PC+4 [31:28], target, 2'b00}.
- R8: Register 0 always reads as zero. Writes to it have no effect.
- R9: The instruction latch loads only in the fetch step. It holds its value until the instruction completes.
- R10: The fetch step advances the PC by 4 using the shared ALU.
- R11: Decoding opcode 0 raises `halt` after 2 cycles, with the PC left at the halt address + 4. `halt` then stays high, and no further memory writes occur.
- R12: The memory address is the PC during fetch and the ALU result latch during the data-access steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Writes `ld_data` into memory word `ld_addr` |
| ld_addr | input | AW | Word index for the load port |
| ld_data | input | 32 | Word written through the load port |
| mem_addr | output | 32 | Byte address presented to the shared memory |
| mem_we | output | 1 | Store strobe from the core |
| mem_wdata | output | 32 | Store data from the core |
| pc | output | 32 | Current program counter |
| halt | output | 1 | High once the halt opcode has been decoded |

## Verification
In every decode step the shared ALU precomputes a branch destination from the immediate field. In the same cycle the operand latches capture the register file. Loads, stores and arithmetic instructions therefore all carry immediate bits through this speculative sum, and the program mixes them with one taken and one untaken branch. The checks confirm that only a taken branch ever moves the PC to that sum: the scoreboard sees the exact sequence of stores, the skipped stores never appear, and the total cycle count up to `halt` equals the per-class step counts summed over the executed path.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EXEC, S_ADDR, S_MEMRD, S_MEMWR,
    S_WBR, S_WBL, S_BRANCH, S_JUMP, S_HALT
  } step_e;

  typedef enum logic [1:0] { B_REG, B_FOUR, B_IMM, B_IMMSH } srcb_e;

  typedef enum logic [2:0] { OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT } aluop_e;

  localparam logic [1:0] PCS_ALU  = 2'd0;
  localparam logic [1:0] PCS_HELD = 2'd1;
  localparam logic [1:0] PCS_JMP  = 2'd2;

  localparam logic [5:0] OPC_HALT  = 6'h00;
  localparam logic [5:0] OPC_ARITH = 6'h01;
  localparam logic [5:0] OPC_J     = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic       pc_we;
    logic       pc_cond;
    logic [1:0] pc_src;
    logic       ir_we;
    logic       ab_we;
    logic       mdr_we;
    logic       aluout_we;
    logic       iord;
    logic       mem_we;
    logic       srca;
    srcb_e      srcb;
    aluop_e     aluop;
    logic       rf_we;
    logic       rf_dst_rd;
    logic       rf_from_mdr;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic aluop_e funct_op(input logic [5:0] fn);
    case (fn)
      FN_SUB:  return OP_SUB;
      FN_AND:  return OP_AND;
      FN_OR:   return OP_OR;
      FN_SLT:  return OP_SLT;
      default: return OP_ADD;
    endcase
  endfunction

  function automatic logic [31:0] alu_calc(input aluop_e op, input logic [31:0] a,
                                           input logic [31:0] b);
    case (op)
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_SLT:  return {31'd0, $signed(a) < $signed(b)};
      default: return a + b;
    endcase
  endfunction

  function automatic logic [31:0] jump_dest(input logic [3:0] region, input logic [25:0] t);
    return {region, t, 2'b00};
  endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  aluop_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    y    = alu_calc(op, a, b);
    zero = (y == '0);
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W  = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ra_a,
  input  logic [RW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [RW-1:0] wa,
  input  logic [W-1:0]  wd
);
  localparam int NREG = 1 << RW;

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

  // R8: register zero never yields a non-zero value
  a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (ra_a == '0) |-> (rd_a == '0));
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  output step_e      step,
  output ctrl_t      c
);
  step_e nxt;

  always_ff @(posedge clk) begin
    if (rst) step <= S_FETCH;
    else     step <= nxt;
  end

  always_comb begin
    nxt = S_FETCH;
    case (step)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (opc)
          OPC_ARITH:      nxt = S_EXEC;
          OPC_LW, OPC_SW: nxt = S_ADDR;
          OPC_BEQ:        nxt = S_BRANCH;
          OPC_J:          nxt = S_JUMP;
          OPC_HALT:       nxt = S_HALT;
          default:        nxt = S_FETCH;
        endcase
      end
      S_EXEC:  nxt = S_WBR;
      S_ADDR:  nxt = (opc == OPC_LW) ? S_MEMRD : S_MEMWR;
      S_MEMRD: nxt = S_WBL;
      S_HALT:  nxt = S_HALT;
      default: nxt = S_FETCH;
    endcase
  end

  always_comb begin
    c = '0;
    c.srcb  = B_REG;
    c.aluop = OP_ADD;
    case (step)
      S_FETCH: begin
        c.ir_we = 1'b1; c.srcb = B_FOUR; c.pc_we = 1'b1; c.pc_src = PCS_ALU;
      end
      S_DECODE: begin
        c.ab_we = 1'b1; c.srcb = B_IMMSH; c.aluout_we = 1'b1;
      end
      S_EXEC: begin
        c.srca = 1'b1; c.aluop = funct_op(fn); c.aluout_we = 1'b1;
      end
      S_ADDR: begin
        c.srca = 1'b1; c.srcb = B_IMM; c.aluout_we = 1'b1;
      end
      S_MEMRD: begin c.iord = 1'b1; c.mdr_we = 1'b1; end
      S_MEMWR: begin c.iord = 1'b1; c.mem_we = 1'b1; end
      S_WBR:   begin c.rf_we = 1'b1; c.rf_dst_rd = 1'b1; end
      S_WBL:   begin c.rf_we = 1'b1; c.rf_from_mdr = 1'b1; end
      S_BRANCH: begin
        c.srca = 1'b1; c.aluop = OP_SUB; c.pc_cond = 1'b1; c.pc_src = PCS_HELD;
      end
      S_JUMP:  begin c.pc_we = 1'b1; c.pc_src = PCS_JMP; end
      default: ;
    endcase
  end

  // R11: once halted the controller never leaves the halt step
  a_r11_halt_lock: assert property (@(posedge clk) disable iff (rst)
    (step == S_HALT) |=> (step == S_HALT));
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [31:0]   ld_data,
  output logic [31:0]   mem_addr,
  output logic          mem_we,
  output logic [31:0]   mem_wdata,
  output logic [31:0]   pc,
  output logic          halt
);
  localparam int W     = 32;
  localparam int RW    = 5;
  localparam int WORDS = 1 << AW;

  step_e step;
  ctrl_t c;
  logic [W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [W-1:0] rf_a, rf_b, alu_a, alu_b, alu_y, pc_next, mem_rd, imm_x;
  logic         alu_zero, pc_load;
  logic [W-1:0] mem [WORDS];

  // named internal events for the assertions
  logic st_fetch, st_branch, st_jump;
  assign st_fetch  = (step == S_FETCH);
  assign st_branch = (step == S_BRANCH);
  assign st_jump   = (step == S_JUMP);

  mc_ctrl u_ctrl (
    .clk (clk), .rst (rst), .opc (ir_q[31:26]), .fn (ir_q[5:0]),
    .step(step), .c (c)
  );

  mc_regfile #(.W(W), .RW(RW)) u_rf (
    .clk (clk), .rst (rst),
    .ra_a(ir_q[25:21]), .ra_b(ir_q[20:16]), .rd_a(rf_a), .rd_b(rf_b),
    .we  (c.rf_we),
    .wa  (c.rf_dst_rd ? ir_q[15:11] : ir_q[20:16]),
    .wd  (c.rf_from_mdr ? mdr_q : aluout_q)
  );

  assign imm_x = sext16(ir_q[15:0]);
  assign alu_a = c.srca ? a_q : pc_q;

  always_comb begin
    case (c.srcb)
      B_REG:   alu_b = b_q;
      B_FOUR:  alu_b = 32'd4;
      B_IMM:   alu_b = imm_x;
      default: alu_b = imm_x << 2;
    endcase
  end

  mc_alu #(.W(W)) u_alu (.op(c.aluop), .a(alu_a), .b(alu_b), .y(alu_y), .zero(alu_zero));

  assign mem_addr  = c.iord ? aluout_q : pc_q;
  assign mem_we    = c.mem_we;
  assign mem_wdata = b_q;
  assign mem_rd    = mem[mem_addr[AW+1:2]];

  always_ff @(posedge clk) begin
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[AW+1:2]] <= mem_wdata;
  end

  always_comb begin
    case (c.pc_src)
      PCS_ALU:  pc_next = alu_y;
      PCS_HELD: pc_next = aluout_q;
      default:  pc_next = jump_dest(pc_q[31:28], ir_q[25:0]);
    endcase
  end
  assign pc_load = c.pc_we | (c.pc_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0; ir_q <= '0; mdr_q <= '0; a_q <= '0; b_q <= '0; aluout_q <= '0;
    end else begin
      if (pc_load)     pc_q     <= pc_next;
      if (c.ir_we)     ir_q     <= mem_rd;
      if (c.mdr_we)    mdr_q    <= mem_rd;
      if (c.ab_we)     begin a_q <= rf_a; b_q <= rf_b; end
      if (c.aluout_we) aluout_q <= alu_y;
    end
  end

  assign pc   = pc_q;
  assign halt = (step == S_HALT);

  // R10: fetch step advances the PC by one word
  a_r10_fetch_step: assert property (@(posedge clk) disable iff (rst)
    st_fetch |=> (pc_q == $past(pc_q) + 32'd4));
  // R9: the instruction latch is frozen outside fetch
  a_r9_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !st_fetch |=> $stable(ir_q));
  // R12: fetch addresses the memory with the PC
  a_r12_fetch_addr: assert property (@(posedge clk) disable iff (rst)
    st_fetch |-> (mem_addr == pc_q));
  // R12: stores address the memory with the ALU result latch
  a_r12_data_addr: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == aluout_q));
  // R6: an unequal compare leaves the PC alone
  a_r6_branch_hold: assert property (@(posedge clk) disable iff (rst)
    (st_branch && !alu_zero) |=> $stable(pc_q));
  // R7: a jump keeps the region bits and lands word-aligned
  a_r7_jump_region: assert property (@(posedge clk) disable iff (rst)
    st_jump |=> (pc_q[1:0] == 2'b00 && pc_q[31:28] == $past(pc_q[31:28])));
  // R11: no stores once halted
  a_r11_no_store: assert property (@(posedge clk) disable iff (rst)
    halt |-> !mem_we);
endmodule

// File: tb/mc_core_tb_top.sv
`timescale 1ns/100ps
module mc_core_tb_top;
  localparam int AW = 6;

  localparam logic [5:0] T_ARITH = 6'h01, T_J = 6'h02, T_BEQ = 6'h04,
                         T_LW = 6'h23, T_SW = 6'h2B;
  localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24,
                         F_OR = 6'h25, F_SLT = 6'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] mem_addr, mem_wdata, pc;
  logic mem_we, halt;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct { logic [31:0] a; logic [31:0] d; string tag; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  mc_core #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .pc(pc), .halt(halt)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {T_ARITH, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic put(input int idx, input logic [31:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = idx[AW-1:0]; ld_data = w;
  endtask

  task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares each store with the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6/R11 unexpected store", mem_addr, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(mem_addr == e.a, {e.tag, " store address"}, mem_addr, e.a);
        chk(mem_wdata == e.d, {e.tag, " store data"}, mem_wdata, e.d);
      end
    end
  end

  initial begin
    // program: word index and instruction (R2 encodings)
    put(0,  enc_i(T_LW, 0, 1, 192));        // r1 = 7
    put(1,  enc_i(T_LW, 0, 2, 196));        // r2 = -3
    put(2,  enc_r(1, 2, 3, F_ADD));         // r3 = 4
    put(3,  enc_i(T_SW, 0, 3, 200));
    put(4,  enc_r(1, 2, 4, F_SUB));         // r4 = 10
    put(5,  enc_i(T_SW, 0, 4, 204));
    put(6,  enc_r(2, 1, 5, F_SLT));         // r5 = 1
    put(7,  enc_i(T_SW, 0, 5, 208));
    put(8,  enc_r(1, 2, 6, F_AND));         // r6 = 5
    put(9,  enc_i(T_SW, 0, 6, 212));
    put(10, enc_r(1, 2, 7, F_OR));          // r7 = all ones
    put(11, enc_i(T_SW, 0, 7, 216));
    put(12, enc_r(1, 1, 0, F_ADD));         // write to r0 ignored
    put(13, enc_i(T_SW, 0, 0, 220));
    put(14, enc_i(T_BEQ, 1, 2, 5));         // not taken
    put(15, enc_i(T_BEQ, 3, 3, 2));         // taken to word 18
    put(16, enc_i(T_SW, 0, 1, 224));        // skipped
    put(17, enc_i(T_SW, 0, 1, 224));        // skipped
    put(18, {T_J, 26'd21});                 // jump to word 21
    put(19, enc_i(T_SW, 0, 1, 228));        // skipped
    put(20, enc_i(T_SW, 0, 1, 228));        // skipped
    put(21, enc_i(T_LW, 0, 8, 236));        // r8 = 240
    put(22, enc_i(T_SW, 8, 2, -8));         // store to 232
    put(23, 32'h0000_0000);                 // halt
    put(48, 32'd7);
    put(49, 32'hFFFF_FFFD);
    put(59, 32'd240);
    @(negedge clk);
    ld_en = 1'b0;

    // driver: expected stores in program order
    expect_store(32'd200, 32'd4,          "R3 add / R9");
    expect_store(32'd204, 32'd10,         "R3 sub");
    expect_store(32'd208, 32'd1,          "R3 slt");
    expect_store(32'd212, 32'd5,          "R3 and");
    expect_store(32'd216, 32'hFFFF_FFFF,  "R3 or");
    expect_store(32'd220, 32'd0,          "R8 zero register");
    expect_store(32'd232, 32'hFFFF_FFFD,  "R4/R5 negative offset");

    @(negedge clk);
    chk(pc == 32'd0, "R1 pc in reset", pc, 32'd0);
    chk(halt == 1'b0, "R1 halt in reset", {31'd0, halt}, 32'd0);
    rst = 1'b0;
    #0.5;
    chk(mem_addr == 32'd0, "R12 first fetch address", mem_addr, 32'd0);
    @(negedge clk);
    chk(pc == 32'd4, "R10 pc after first fetch", pc, 32'd4);

    begin
      int guard;
      guard = 0;
      while (!halt && guard < 2000) begin
        @(negedge clk);
        guard++;
      end
      if (!halt) chk(1'b0, "watchdog: no halt", {31'd0, halt}, 32'd1);
    end

    // loads 5, arith 4, store 4, branch 3, jump 3, halt decode 2
    chk(cyc == 3*5 + 6*4 + 7*4 + 2*3 + 1*3 + 2,
        "R3 R4 R5 R6 R7 R11 cycle total", cyc, 3*5 + 6*4 + 7*4 + 2*3 + 1*3 + 2);
    chk(pc == 32'd96, "R11 pc after halt", pc, 32'd96);
    chk(sb.size() == 0, "R6 R7 all expected stores seen", sb.size(), 0);

    repeat (10) @(negedge clk);
    chk(halt == 1'b1, "R11 halt stays high", {31'd0, halt}, 32'd1);
    chk(pc == 32'd96, "R11 pc frozen", pc, 32'd96);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule